// File: doc/BRIEF.md
# Prioritized Compute Queue Dispatcher

This block places software-submitted compute queues onto the hardware queue slots of a group of compute engines. There are eight engines with eight slots each by default. A submitted queue is a queue id plus a one-bit priority. It is held in a holding store until some engine slot is empty. From then on, one held queue per clock is placed into a free slot. Placement continues until every slot is occupied or the store is empty.

High-priority queues always leave the store before low-priority ones. Within a priority level, queues leave in the order they were submitted. A queue already in a slot stays there until its engine releases the slot, so low-priority work that has been placed is never evicted. The block only decides placement. Running the work inside a queue is the engines' job.

Top module: `queue_dispatcher`

## Requirements
- R1: After reset no assignment is reported, all 64 slots are empty (`eng_free` all ones) and `sub_ready` is 1.
- R2: A held queue is assigned at the first clock edge at which the store is non-empty and some slot is free. `asg_valid` and its fields are registered and show the assignment after that edge.
- R3: At most one assignment is made per clock. No assignment is made while all slots are occupied.
- R4: When `sub_hi`=1 queues (high priority) are held, the oldest of them is assigned before any `sub_hi`=0 queue. Within one level, queues are assigned in submission order.
- R5: The target is the lowest-numbered engine that has a free slot, and within it the lowest-numbered free slot.
- R6: The store holds at most 32 queues. `sub_ready` is 0 while 32 are held, and a submission offered while `sub_ready` is 0 is dropped: it is never assigned.
- R7: Setting bit e*8+s of `rel_slots` for one clock empties slot s of engine e. The slot can be chosen from the next edge on, never at the edge that releases it.
- R8: An occupied slot is never assigned again until it has been released, so placed queues are never preempted.
- R9: `eng_free[e]` is 1 exactly when engine e has at least one empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_valid | input | 1 | Submission offered this cycle |
| sub_hi | input | 1 | Priority of the submission, 1 = high |
| sub_qid | input | 8 | Queue id of the submission |
| sub_ready | output | 1 | Store can accept a submission |
| rel_slots | input | 64 | One bit per slot, bit e*8+s releases slot s of engine e |
| eng_free | output | 8 | Per-engine flag: at least one empty slot |
| asg_valid | output | 1 | An assignment was made at the last edge |
| asg_eng | output | 3 | Engine of the assignment |
| asg_slot | output | 3 | Slot of the assignment |
| asg_qid | output | 8 | Queue id that was assigned |

## Verification
Two events can fall on the same edge: a slot release and the choice of a target slot. A submission at the full threshold can also meet an assignment that frees store space. The bench provokes both. It fills all 64 slots, keeps the store saturated with a mix of both priorities, and then releases single slots, pairs of slots and whole engines, first in directed patterns and then in a long random run that releases and submits at the same time. On every clock a behavioural model with two queues and an occupancy vector predicts the next assignment. That prediction shows whether a slot released at an edge was wrongly reused at that same edge, and whether an offer made while the store was full was wrongly accepted.

// File: rtl/queue_dispatcher.sv
module queue_dispatcher #(
  parameter int NUM_ENG = 8,
  parameter int SLOTS   = 8,
  parameter int DEPTH   = 32,
  parameter int QID_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sub_valid,
  input  logic                       sub_hi,
  input  logic [QID_W-1:0]           sub_qid,
  output logic                       sub_ready,
  input  logic [NUM_ENG*SLOTS-1:0]   rel_slots,
  output logic [NUM_ENG-1:0]         eng_free,
  output logic                       asg_valid,
  output logic [$clog2(NUM_ENG)-1:0] asg_eng,
  output logic [$clog2(SLOTS)-1:0]   asg_slot,
  output logic [QID_W-1:0]           asg_qid
);
  // NUM_ENG, SLOTS and DEPTH are powers of two (pointers and indices wrap naturally)
  localparam int EW = $clog2(NUM_ENG);
  localparam int SW = $clog2(SLOTS);
  localparam int IW = EW + SW;
  localparam int NS = NUM_ENG * SLOTS;
  localparam int PW = $clog2(DEPTH);

  logic [NS-1:0]    occ;
  logic [QID_W-1:0] hmem [DEPTH];
  logic [QID_W-1:0] lmem [DEPTH];
  logic [PW-1:0]    hrd, hwr, lrd, lwr;
  logic [PW:0]      hcnt, lcnt;
  logic [PW+1:0]    total;
  logic             push_h, push_l, pop_h, pop_l, have_h, have_l;
  logic             hit, fire;
  logic [IW-1:0]    idx;

  assign total     = (PW+2)'(hcnt) + (PW+2)'(lcnt);
  assign sub_ready = total < (PW+2)'(DEPTH);
  assign push_h    = sub_valid & sub_ready & sub_hi;
  assign push_l    = sub_valid & sub_ready & ~sub_hi;
  assign have_h    = hcnt != '0;
  assign have_l    = lcnt != '0;
  assign fire      = hit & (have_h | have_l);
  assign pop_h     = fire & have_h;
  assign pop_l     = fire & ~have_h & have_l;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_free
    assign eng_free[e] = ~&occ[e*SLOTS +: SLOTS];
  end

  always_ff @(posedge clk) begin
    if (push_h) hmem[hwr] <= sub_qid;
    if (push_l) lmem[lwr] <= sub_qid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ       <= '0;
      hrd       <= '0;
      hwr       <= '0;
      lrd       <= '0;
      lwr       <= '0;
      hcnt      <= '0;
      lcnt      <= '0;
      asg_valid <= 1'b0;
      asg_eng   <= '0;
      asg_slot  <= '0;
      asg_qid   <= '0;
    end else begin
      occ <= (occ & ~rel_slots) | (fire ? (NS'(1) << idx) : '0);
      if (push_h) hwr <= hwr + 1'b1;
      if (push_l) lwr <= lwr + 1'b1;
      if (pop_h)  hrd <= hrd + 1'b1;
      if (pop_l)  lrd <= lrd + 1'b1;
      hcnt <= hcnt + (PW+1)'(push_h) - (PW+1)'(pop_h);
      lcnt <= lcnt + (PW+1)'(push_l) - (PW+1)'(pop_l);
      asg_valid <= fire;
      if (fire) begin
        asg_eng  <= idx[IW-1:SW];
        asg_slot <= idx[SW-1:0];
        asg_qid  <= have_h ? hmem[hrd] : lmem[lrd];
      end
    end
  end
endmodule

// File: rtl/queue_dispatcher_chk.sv
module queue_dispatcher_chk #(
  parameter int NUM_ENG = 8,
  parameter int SLOTS   = 8,
  parameter int DEPTH   = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_ENG*SLOTS-1:0]     occ,
  input logic [$clog2(DEPTH):0]       hcnt,
  input logic [$clog2(DEPTH):0]       lcnt,
  input logic [NUM_ENG-1:0]           eng_free,
  input logic                         asg_valid,
  input logic [$clog2(NUM_ENG)-1:0]   asg_eng,
  input logic [$clog2(SLOTS)-1:0]     asg_slot
);
  localparam int NS = NUM_ENG * SLOTS;
  localparam int IW = $clog2(NUM_ENG) + $clog2(SLOTS);
  localparam int CW = $clog2(DEPTH) + 2;

  logic [NS-1:0] prev_occ;
  logic [IW-1:0] flat;
  logic [CW-1:0] held;

  assign flat = {asg_eng, asg_slot};
  assign held = CW'(hcnt) + CW'(lcnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_occ <= '0;
    else        prev_occ <= occ;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held <= CW'(DEPTH));

  // R2
  prompt_assign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|eng_free) && held != '0) |=> asg_valid);

  // R3
  full_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_free == '0) |=> !asg_valid);

  // R3
  single_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ & ~prev_occ) <= 1);

  // R8
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid |-> (!prev_occ[flat] && occ[flat]));

  // R5
  lowest_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid |-> ((~prev_occ & ((NS'(1) << flat) - NS'(1))) == '0));
endmodule

bind queue_dispatcher queue_dispatcher_chk #(
  .NUM_ENG(NUM_ENG), .SLOTS(SLOTS), .DEPTH(DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .occ(occ), .hcnt(hcnt), .lcnt(lcnt),
  .eng_free(eng_free), .asg_valid(asg_valid), .asg_eng(asg_eng),
  .asg_slot(asg_slot)
);

// File: tb/queue_dispatcher_test.sv
`timescale 1ns/1ps
module queue_dispatcher_test;
  localparam int NE = 8, SL = 8, DEPTH = 32, NS = 64;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          sub_valid = 1'b0, sub_hi = 1'b0;
  logic [7:0]    sub_qid = '0;
  logic [NS-1:0] rel_slots = '0;
  logic          sub_ready, asg_valid;
  logic [NE-1:0] eng_free;
  logic [2:0]    asg_eng, asg_slot;
  logic [7:0]    asg_qid;

  queue_dispatcher uut (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_hi(sub_hi),
    .sub_qid(sub_qid), .sub_ready(sub_ready), .rel_slots(rel_slots),
    .eng_free(eng_free), .asg_valid(asg_valid), .asg_eng(asg_eng),
    .asg_slot(asg_slot), .asg_qid(asg_qid)
  );

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit started = 0, done = 0;

  logic [NS-1:0] m_occ;
  int hq[$], lq[$];
  bit e_valid;
  int e_eng, e_slot, e_qid;
  int f;
  bit rdy;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_occ = '0; hq.delete(); lq.delete();
      e_valid = 0; started = 1;
    end else begin
      f = -1;
      for (int i = NS - 1; i >= 0; i--) if (!m_occ[i]) f = i;
      rdy = (hq.size() + lq.size()) < DEPTH;
      e_valid = 0;
      if (f >= 0 && (hq.size() != 0 || lq.size() != 0)) begin
        e_valid = 1; e_eng = f / SL; e_slot = f % SL;
        if (hq.size() != 0) e_qid = hq.pop_front();
        else                e_qid = lq.pop_front();
      end
      m_occ = m_occ & ~rel_slots;
      if (e_valid) m_occ[f] = 1'b1;
      if (sub_valid && rdy) begin
        if (sub_hi) hq.push_back(int'(sub_qid));
        else        lq.push_back(int'(sub_qid));
      end
    end
  end

  function automatic logic [NE-1:0] model_free();
    logic [NE-1:0] r;
    for (int e = 0; e < NE; e++) r[e] = ~&m_occ[e*SL +: SL];
    return r;
  endfunction

  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      vectors++;
      // R2 R3 R8: assignment made exactly when predicted
      if (asg_valid !== e_valid) begin
        miscompares++;
        $display("FAIL R2 R3 R8 asg_valid act=%0b exp=%0b t=%0t", asg_valid, e_valid, $time);
      end else if (e_valid) begin
        // R5 R7: target slot
        if (asg_eng !== 3'(e_eng) || asg_slot !== 3'(e_slot)) begin
          miscompares++;
          $display("FAIL R5 R7 target act=%0d.%0d exp=%0d.%0d t=%0t", asg_eng, asg_slot, e_eng, e_slot, $time);
        end
        // R4: priority and FIFO order
        if (asg_qid !== 8'(e_qid)) begin
          miscompares++;
          $display("FAIL R4 qid act=%0d exp=%0d t=%0t", asg_qid, e_qid, $time);
        end
      end
      // R6: back-pressure
      if (sub_ready !== ((hq.size() + lq.size()) < DEPTH)) begin
        miscompares++;
        $display("FAIL R6 sub_ready act=%0b exp=%0b t=%0t", sub_ready, (hq.size() + lq.size()) < DEPTH, $time);
      end
      // R9: per-engine free flags
      if (eng_free !== model_free()) begin
        miscompares++;
        $display("FAIL R9 eng_free act=%h exp=%h t=%0t", eng_free, model_free(), $time);
      end
    end
  end

  task automatic cyc(input bit v, input bit hi, input int q, input logic [NS-1:0] rel);
    @(negedge clk);
    sub_valid = v; sub_hi = hi; sub_qid = 8'(q); rel_slots = rel;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    // R1: reset state
    if (asg_valid !== 1'b0 || eng_free !== 8'hFF || sub_ready !== 1'b1) begin
      miscompares++;
      $display("FAIL R1 reset act=%0b/%h/%0b exp=0/ff/1", asg_valid, eng_free, sub_ready);
    end
    // R2: immediate placement while slots are free
    for (int i = 0; i < 3; i++) cyc(1, 0, 1 + i, '0);
    cyc(1, 1, 4, '0);
    cyc(0, 0, 0, '0);
    cyc(0, 0, 0, '0);
    // R3 R6: fill every slot, then saturate the store with mixed priorities
    for (int i = 0; i < 110; i++) cyc(1, (i % 3) == 0, 16 + i, '0);
    cyc(0, 0, 0, '0);
    // R7: single release, pair release, whole engine release
    cyc(0, 0, 0, 64'(1) << 37);
    cyc(0, 0, 0, '0);
    cyc(0, 0, 0, '0);
    cyc(0, 0, 0, (64'(1) << 5) | (64'(1) << 60));
    cyc(1, 1, 200, '0);
    cyc(0, 0, 0, '0);
    cyc(0, 0, 0, 64'hFF << 16);
    // R7: release a lower slot while a higher one is still free
    cyc(0, 0, 0, 64'(1) << 2);
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, '0);
    // R4 R5 R8: random traffic with concurrent releases
    for (int i = 0; i < 4000; i++)
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, $urandom_range(0, 255),
          {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} &
          {$urandom, $urandom} & {$urandom, $urandom});
    // drain everything
    cyc(0, 0, 0, '1);
    for (int i = 0; i < 80; i++) cyc(0, 0, 0, '0);
    cyc(0, 0, 0, '1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, '0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule